// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block is the operand stage of a small 8-bit processor core with a 16-bit address space. The decoder hands it a mode code, a byte or word size flag, a read or write direction and the current program counter. The unit then reads any operand bytes that follow the opcode, one per cycle, through a single byte-wide memory port. It builds the 16-bit effective address from those bytes and from the index pair H:X or the stack pointer. Finally it performs the data access. The result is the data read, the advanced program counter and, for the post-increment mode, the next value of H:X.

Words are big-endian: the high byte is at the effective address and the low byte is at the next address. All address arithmetic wraps modulo 2^16, and offsets are always zero-extended. The memory system can refuse any read through `mem_reject`. A refused read ends the operation at once with an error and returns the caller's program counter and H:X unchanged. Opcode decode and arithmetic are outside this block.

Top module: `opnd_fetch_unit`

## Requirements
- R1: Mode 0 (direct short) reads one byte at PC, uses {0x00, byte} as the address and returns PC+1.
- R2: Mode 1 (direct long) reads the address high byte at PC and the low byte at PC+1, and returns PC+2.
- R3: Mode 2 (indexed, no offset) uses H:X as the address, reads no operand byte and returns PC unchanged. Its single data read is issued in the cycle after `start` is taken.
- R4: Modes 3 and 4 add to H:X, modulo 2^16, an offset that is zero-extended: one byte at PC for mode 3 (PC+1 returned) or a big-endian word at PC, PC+1 for mode 4 (PC+2 returned).
- R5: Modes 5 and 6 form the address as modes 3 and 4 do, but with the stack pointer as base.
- R6: With `is_word`=1 the access moves the high byte at the address and the low byte at address+1, one byte per cycle. A byte read returns {0x00, byte} on `rdata`. `done` follows the `start` edge by exactly (operand bytes + data bytes) cycles.
- R7: Mode 7 accesses H:X with no offset. On success it returns `hx_out`=H:X+1 (16-bit wrap) with `hx_upd`=1; every other mode returns `hx_out`=H:X with `hx_upd`=0.
- R8: Mode 8 (immediate pair) reads the bytes at PC and PC+1 and returns them as {byte@PC, byte@PC+1}, with PC+2 and no data access. A write request in mode 8 ends with `done` and `err` on the `start` edge and makes no memory access.
- R9: Mode 9 (bit direct) addresses like mode 0 and always works on one byte. A write reads the target byte, replaces only bit `bit_idx` with `wdata[0]` and writes it back, which takes three cycles in total. A read returns the byte.
- R10: A read refused by `mem_reject` ends the operation in that cycle with `done`=1 and `err`=1, `rdata`=0, `pc_out`=PC, `hx_out`=H:X and `hx_upd`=0, and no write follows it.
- R11: Mode codes 10 to 15 are unsupported. They end with `done`=1 and `err`=1 on the `start` edge, with `pc_out`=PC and `hx_out`=H:X.
- R12: After reset `busy`, `done`, `err`, `hx_upd`, `mem_rd` and `mem_wr` are 0 and the result outputs are zero. `done` is never high while `busy` is high, memory strobes occur only while `busy` is high, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken only while not busy |
| mode | input | 4 | Addressing mode code (see R1 to R11) |
| is_word | input | 1 | 1 = 16-bit data access, 0 = byte |
| is_write | input | 1 | 1 = store, 0 = load |
| wdata | input | 16 | Store data; bit 0 is the new bit in mode 9 |
| bit_idx | input | 3 | Bit position replaced in mode 9 |
| pc_in | input | 16 | PC of the first operand byte |
| hx_in | input | 16 | Index pair H:X |
| sp_in | input | 16 | Stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe; `mem_rdata` is used in the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_reject | input | 1 | Read refused; sampled only while `mem_rd` is high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with error; valid with `done` |
| rdata | output | 16 | Data or immediate pair read |
| pc_out | output | 16 | PC after the operand bytes |
| hx_out | output | 16 | H:X after the operation |
| hx_upd | output | 1 | `hx_out` carries a post-increment |

## Verification
The bench builds the unit with the default byte width of 8, which gives 16-bit addresses and a 3-bit bit index. Its memory model aliases on ten address bits and folds address bits 9:8 into each stored byte. As a result, a carry into the address high byte, a sign-extended offset or a wrong base register changes the data returned. A refusing region at high byte 0xEE can be reached from an operand fetch, from a long-direct data read and from H:X, so aborts are exercised in every phase.

// File: rtl/ofu_pkg.sv
`timescale 1ns/1ps
package ofu_pkg;

    typedef enum logic [3:0] {
        M_DIR_S    = 4'd0,
        M_DIR_L    = 4'd1,
        M_IDX0     = 4'd2,
        M_IDX1     = 4'd3,
        M_IDX2     = 4'd4,
        M_STK1     = 4'd5,
        M_STK2     = 4'd6,
        M_IDX0_INC = 4'd7,
        M_IMM_PAIR = 4'd8,
        M_DIR_BIT  = 4'd9
    } mode_e;

    typedef enum logic [1:0] {
        B_ZERO = 2'd0,
        B_HX   = 2'd1,
        B_SP   = 2'd2
    } base_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_OPND = 2'd1,
        S_DATA = 2'd2,
        S_RMW  = 2'd3
    } state_e;

    typedef struct packed {
        logic       legal;
        logic [1:0] n_opnd;
        base_e      base;
        logic       post_inc;
        logic       rd_only;
        logic       bit_mode;
        logic       imm_only;
    } mdec_t;

endpackage

// File: rtl/ofu_mode_dec.sv
`timescale 1ns/1ps
module ofu_mode_dec
    import ofu_pkg::*;
(
    input  logic [3:0] mode_code,
    output mdec_t      dec
);

    always_comb begin
        dec       = '0;
        dec.legal = 1'b1;
        dec.base  = B_ZERO;
        case (mode_code)
            M_DIR_S:    dec.n_opnd = 2'd1;
            M_DIR_L:    dec.n_opnd = 2'd2;
            M_IDX0:     dec.base   = B_HX;
            M_IDX1:     begin dec.base = B_HX; dec.n_opnd = 2'd1; end
            M_IDX2:     begin dec.base = B_HX; dec.n_opnd = 2'd2; end
            M_STK1:     begin dec.base = B_SP; dec.n_opnd = 2'd1; end
            M_STK2:     begin dec.base = B_SP; dec.n_opnd = 2'd2; end
            M_IDX0_INC: begin dec.base = B_HX; dec.post_inc = 1'b1; end
            M_IMM_PAIR: begin dec.n_opnd = 2'd2; dec.rd_only = 1'b1; dec.imm_only = 1'b1; end
            M_DIR_BIT:  begin dec.n_opnd = 2'd1; dec.bit_mode = 1'b1; end
            default:    dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/ofu_bit_merge.sv
`timescale 1ns/1ps
module ofu_bit_merge #(
    parameter int BYTE_W = 8,
    localparam int BIT_W = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] old_byte,
    input  logic [BIT_W-1:0]  pos,
    input  logic              new_bit,
    output logic [BYTE_W-1:0] merged
);

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign merged[i] = (pos == BIT_W'(i)) ? new_bit : old_byte[i];
    end

endmodule

// File: rtl/opnd_fetch_unit.sv
`timescale 1ns/1ps
module opnd_fetch_unit
    import ofu_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int BIT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic              is_word,
    input  logic              is_write,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] hx_in,
    input  logic [WORD_W-1:0] sp_in,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_reject,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] hx_out,
    output logic              hx_upd
);

    typedef struct packed {
        state_e            st;
        logic [3:0]        mode;
        logic              wr;
        logic              word;
        logic [BIT_W-1:0]  bidx;
        logic [WORD_W-1:0] wdat;
        logic [WORD_W-1:0] pc0;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] hx;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] opnd;
        logic [WORD_W-1:0] ea;
        logic [WORD_W-1:0] data;
        logic [1:0]        cnt;
        logic              idx;
        logic              done;
        logic              err;
        logic              upd;
        logic [WORD_W-1:0] r_data;
        logic [WORD_W-1:0] r_pc;
        logic [WORD_W-1:0] r_hx;
    } regs_t;

    regs_t q, d;
    mdec_t dec_in, dec_q;

    logic [BYTE_W-1:0] rmw_byte;
    logic [WORD_W-1:0] nx_opnd, nx_data, acc_addr, ok_data;
    logic              fin_ok, fin_bad, first_hi;
    logic              dec_unused;

    ofu_mode_dec u_dec_in (.mode_code(mode),   .dec(dec_in));
    ofu_mode_dec u_dec_q  (.mode_code(q.mode), .dec(dec_q));

    ofu_bit_merge #(.BYTE_W(BYTE_W)) u_merge (
        .old_byte (q.data[BYTE_W-1:0]),
        .pos      (q.bidx),
        .new_bit  (q.wdat[0]),
        .merged   (rmw_byte)
    );

    assign dec_unused = ^{dec_in.post_inc, dec_in.imm_only,
                          dec_q.legal, dec_q.n_opnd, dec_q.base, dec_q.rd_only};

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = q.pc;
        mem_wdata = '0;
        fin_ok    = 1'b0;
        fin_bad   = 1'b0;
        ok_data   = '0;
        first_hi  = q.word && !q.idx;
        nx_opnd   = {q.opnd[BYTE_W-1:0], mem_rdata};
        nx_data   = q.word ? {q.data[BYTE_W-1:0], mem_rdata} : {{BYTE_W{1'b0}}, mem_rdata};
        acc_addr  = q.ea + {{(WORD_W-1){1'b0}}, q.idx};

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.mode = mode;
                    d.wr   = is_write;
                    d.word = is_word && !dec_in.bit_mode;
                    d.bidx = bit_idx;
                    d.wdat = wdata;
                    d.pc0  = pc_in;
                    d.pc   = pc_in;
                    d.hx   = hx_in;
                    d.ea   = hx_in;
                    d.opnd = '0;
                    d.data = '0;
                    d.idx  = 1'b0;
                    d.cnt  = dec_in.n_opnd - 2'd1;
                    case (dec_in.base)
                        B_HX:    d.base = hx_in;
                        B_SP:    d.base = sp_in;
                        default: d.base = '0;
                    endcase
                    if (!dec_in.legal || (is_write && dec_in.rd_only))
                        fin_bad = 1'b1;
                    else if (dec_in.n_opnd == 2'd0)
                        d.st = S_DATA;
                    else
                        d.st = S_OPND;
                end
            end
            S_OPND: begin
                mem_rd   = 1'b1;
                mem_addr = q.pc;
                if (mem_reject) begin
                    fin_bad = 1'b1;
                end else begin
                    d.opnd = nx_opnd;
                    d.pc   = q.pc + 1'b1;
                    d.cnt  = q.cnt - 2'd1;
                    if (q.cnt == 2'd0) begin
                        if (dec_q.imm_only) begin
                            fin_ok  = 1'b1;
                            ok_data = nx_opnd;
                        end else begin
                            d.ea = q.base + nx_opnd;
                            d.st = S_DATA;
                        end
                    end
                end
            end
            S_DATA: begin
                mem_addr = acc_addr;
                if (!q.wr || dec_q.bit_mode) begin
                    mem_rd = 1'b1;
                    if (mem_reject) begin
                        fin_bad = 1'b1;
                    end else begin
                        d.data = nx_data;
                        if (first_hi) begin
                            d.idx = 1'b1;
                        end else if (dec_q.bit_mode && q.wr) begin
                            d.st = S_RMW;
                        end else begin
                            fin_ok  = 1'b1;
                            ok_data = nx_data;
                        end
                    end
                end else begin
                    mem_wr    = 1'b1;
                    mem_wdata = first_hi ? q.wdat[WORD_W-1:BYTE_W] : q.wdat[BYTE_W-1:0];
                    if (first_hi)
                        d.idx = 1'b1;
                    else
                        fin_ok = 1'b1;
                end
            end
            S_RMW: begin
                mem_wr    = 1'b1;
                mem_addr  = q.ea;
                mem_wdata = rmw_byte;
                fin_ok    = 1'b1;
                ok_data   = q.data;
            end
            default: d.st = S_IDLE;
        endcase

        if (fin_bad) begin
            d.st     = S_IDLE;
            d.done   = 1'b1;
            d.err    = 1'b1;
            d.upd    = 1'b0;
            d.r_data = '0;
            d.r_pc   = d.pc0;
            d.r_hx   = d.hx;
        end
        if (fin_ok) begin
            d.st     = S_IDLE;
            d.done   = 1'b1;
            d.upd    = dec_q.post_inc;
            d.r_data = ok_data;
            d.r_pc   = d.pc;
            d.r_hx   = dec_q.post_inc ? q.hx + 1'b1 : q.hx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign busy   = (q.st != S_IDLE);
    assign done   = q.done;
    assign err    = q.err;
    assign rdata  = q.r_data;
    assign pc_out = q.r_pc;
    assign hx_out = q.r_hx;
    assign hx_upd = q.upd;

endmodule

// File: rtl/ofu_chk.sv
`timescale 1ns/1ps
module ofu_chk #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        mode,
    input logic              is_word,
    input logic              is_write,
    input logic [WORD_W-1:0] hx_in,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_reject,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              hx_upd
);

    // R12
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R12
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    reject_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_reject) |=> (done && err));

    // R10
    reject_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_reject) |=> !mem_wr);

    // R10
    err_noinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !hx_upd);

    // R8
    imm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_write && mode == 4'd8) |=> (done && err && !mem_wr && !mem_rd));

    // R11
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode >= 4'd10) |=> (done && err));

    // R3
    idx0_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd2 && !is_write && !is_word) |=> (mem_rd && mem_addr == $past(hx_in)));

endmodule

bind opnd_fetch_unit ofu_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .is_word    (is_word),
    .is_write   (is_write),
    .hx_in      (hx_in),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_reject (mem_reject),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .hx_upd     (hx_upd)
);

// File: tb/sim_opnd_fetch_unit.sv
`timescale 1ns/1ps
module sim_opnd_fetch_unit;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  mode;
        logic        wr;
        logic        word;
        logic [15:0] pc;
        logic [15:0] hx;
        logic [15:0] sp;
        logic [15:0] e_data;
        logic [15:0] e_pc;
        logic [15:0] e_hx;
        logic        e_upd;
        logic        e_err;
        logic [3:0]  e_cyc;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  4'd0,  1'b0, 1'b0, 16'h0020, 16'h0300, 16'h0000, 16'h0020, 16'h0021, 16'h0300, 1'b0, 1'b0, 4'd2}, // R1
        '{4'd6,  4'd0,  1'b0, 1'b1, 16'h0020, 16'h0300, 16'h0000, 16'h201F, 16'h0021, 16'h0300, 1'b0, 1'b0, 4'd3}, // R6
        '{4'd2,  4'd1,  1'b0, 1'b1, 16'h0040, 16'h0300, 16'h0000, 16'h4243, 16'h0042, 16'h0300, 1'b0, 1'b0, 4'd4}, // R2
        '{4'd3,  4'd2,  1'b0, 1'b0, 16'h0050, 16'h1234, 16'h0000, 16'h00C9, 16'h0050, 16'h1234, 1'b0, 1'b0, 4'd1}, // R3
        '{4'd4,  4'd3,  1'b0, 1'b0, 16'h0060, 16'h12F0, 16'h0000, 16'h0073, 16'h0061, 16'h12F0, 1'b0, 1'b0, 4'd2}, // R4
        '{4'd4,  4'd3,  1'b0, 1'b0, 16'h0060, 16'hFFF0, 16'h0000, 16'h0070, 16'h0061, 16'hFFF0, 1'b0, 1'b0, 4'd2}, // R4 wrap
        '{4'd4,  4'd4,  1'b0, 1'b1, 16'h0070, 16'h0100, 16'h0000, 16'h7170, 16'h0072, 16'h0100, 1'b0, 1'b0, 4'd4}, // R4
        '{4'd5,  4'd5,  1'b0, 1'b0, 16'h0080, 16'h5555, 16'h0200, 16'h0082, 16'h0081, 16'h5555, 1'b0, 1'b0, 4'd2}, // R5
        '{4'd5,  4'd6,  1'b0, 1'b1, 16'h0090, 16'h0300, 16'h0100, 16'h9190, 16'h0092, 16'h0300, 1'b0, 1'b0, 4'd4}, // R5
        '{4'd7,  4'd7,  1'b0, 1'b1, 16'h00A0, 16'h00FF, 16'h0000, 16'h00FE, 16'h00A0, 16'h0100, 1'b1, 1'b0, 4'd2}, // R7
        '{4'd8,  4'd8,  1'b0, 1'b0, 16'h00B0, 16'h0300, 16'h0000, 16'h4F4E, 16'h00B2, 16'h0300, 1'b0, 1'b0, 4'd2}, // R8
        '{4'd8,  4'd8,  1'b1, 1'b0, 16'h00B0, 16'h0300, 16'h0000, 16'h0000, 16'h00B0, 16'h0300, 1'b0, 1'b1, 4'd0}, // R8
        '{4'd11, 4'd12, 1'b0, 1'b0, 16'h0020, 16'h0300, 16'h0000, 16'h0000, 16'h0020, 16'h0300, 1'b0, 1'b1, 4'd0}, // R11
        '{4'd10, 4'd1,  1'b0, 1'b1, 16'h0011, 16'h0300, 16'h0000, 16'h0000, 16'h0011, 16'h0300, 1'b0, 1'b1, 4'd3}, // R10
        '{4'd10, 4'd0,  1'b0, 1'b0, 16'hEE00, 16'h0300, 16'h0000, 16'h0000, 16'hEE00, 16'h0300, 1'b0, 1'b1, 4'd1}, // R10
        '{4'd10, 4'd7,  1'b0, 1'b0, 16'h0020, 16'hEE10, 16'h0000, 16'h0000, 16'h0020, 16'hEE10, 1'b0, 1'b1, 4'd1}, // R10
        '{4'd9,  4'd9,  1'b0, 1'b1, 16'h0030, 16'h0300, 16'h0000, 16'h0030, 16'h0031, 16'h0300, 1'b0, 1'b0, 4'd2}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic        is_word = 1'b0;
    logic        is_write = 1'b0;
    logic [15:0] wdata = '0;
    logic [2:0]  bit_idx = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] hx_in = '0;
    logic [15:0] sp_in = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_reject;
    logic        busy, done, err, hx_upd;
    logic [15:0] rdata, pc_out, hx_out;

    logic [7:0]  mem [1024];
    int          wr_count = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    opnd_fetch_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_word(is_word),
        .is_write(is_write), .wdata(wdata), .bit_idx(bit_idx), .pc_in(pc_in),
        .hx_in(hx_in), .sp_in(sp_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_reject(mem_reject), .busy(busy), .done(done), .err(err),
        .rdata(rdata), .pc_out(pc_out), .hx_out(hx_out), .hx_upd(hx_upd)
    );

    assign mem_rdata  = mem[mem_addr[9:0]];
    assign mem_reject = (mem_addr[15:8] == 8'hEE);

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic w, input logic wd,
                       input logic [15:0] wv, input logic [2:0] b,
                       input logic [15:0] pc, input logic [15:0] hx,
                       input logic [15:0] sp, output int cyc);
        @(negedge clk);
        mode = m; is_write = w; is_word = wd; wdata = wv; bit_idx = b;
        pc_in = pc; hx_in = hx; sp_in = sp; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        int w0;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = ~i[7:0] ^ {6'b0, i[9:8]};
        end
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk(!busy && !done && !err && !hx_upd && !mem_rd && !mem_wr, "R12", "reset flags",
            {10'b0, busy, done, err, hx_upd, mem_rd, mem_wr}, 16'h0);
        chk(rdata == 16'h0 && pc_out == 16'h0 && hx_out == 16'h0, "R12", "reset results",
            rdata | pc_out | hx_out, 16'h0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            w0 = wr_count;
            run(VEC[i].mode, VEC[i].wr, VEC[i].word, 16'h0, 3'd0,
                VEC[i].pc, VEC[i].hx, VEC[i].sp, cyc);
            chk(done == 1'b1, tag, $sformatf("done v%0d", i), {15'b0, done}, 16'h1);
            chk(err == VEC[i].e_err, tag, $sformatf("err v%0d", i), {15'b0, err}, {15'b0, VEC[i].e_err});
            chk(rdata == VEC[i].e_data, tag, $sformatf("rdata v%0d", i), rdata, VEC[i].e_data);
            chk(pc_out == VEC[i].e_pc, tag, $sformatf("pc v%0d", i), pc_out, VEC[i].e_pc);
            chk(hx_out == VEC[i].e_hx, tag, $sformatf("hx v%0d", i), hx_out, VEC[i].e_hx);
            chk(hx_upd == VEC[i].e_upd, tag, $sformatf("upd v%0d", i), {15'b0, hx_upd}, {15'b0, VEC[i].e_upd});
            chk(cyc == int'(VEC[i].e_cyc), tag, $sformatf("cycles v%0d", i), 16'(cyc), {12'b0, VEC[i].e_cyc});
            chk(wr_count == w0, tag, $sformatf("no write v%0d", i), 16'(wr_count - w0), 16'h0);
        end

        // R12: done is a single-cycle pulse
        @(posedge clk);
        #1;
        chk(!done, "R12", "done pulse", {15'b0, done}, 16'h0);

        // R4 R6: indexed byte offset, word store big-endian
        w0 = wr_count;
        run(4'd3, 1'b1, 1'b1, 16'hA55A, 3'd0, 16'h0060, 16'h0100, 16'h0, cyc);
        @(negedge clk);
        chk(mem[10'h19F] == 8'hA5, "R6", "word store hi", {8'h0, mem[10'h19F]}, 16'h00A5);
        chk(mem[10'h1A0] == 8'h5A, "R6", "word store lo", {8'h0, mem[10'h1A0]}, 16'h005A);
        chk(cyc == 3 && wr_count - w0 == 2, "R4", "store cycles", 16'(cyc), 16'd3);
        chk(pc_out == 16'h0061 && !err, "R4", "store pc", pc_out, 16'h0061);

        // R6: byte store touches one byte only
        run(4'd0, 1'b1, 1'b0, 16'h1234, 3'd0, 16'h0020, 16'h0300, 16'h0, cyc);
        @(negedge clk);
        chk(mem[10'h0DF] == 8'h34, "R6", "byte store", {8'h0, mem[10'h0DF]}, 16'h0034);
        chk(mem[10'h0E0] == 8'h1F, "R6", "byte store neighbour", {8'h0, mem[10'h0E0]}, 16'h001F);

        // R9: clear bit 4, other wdata bits and is_word ignored
        w0 = wr_count;
        run(4'd9, 1'b1, 1'b1, 16'hFFFE, 3'd4, 16'h0030, 16'h0300, 16'h0, cyc);
        @(negedge clk);
        chk(mem[10'h0CF] == 8'h20, "R9", "bit clear", {8'h0, mem[10'h0CF]}, 16'h0020);
        chk(cyc == 3 && wr_count - w0 == 1, "R9", "rmw cycles", 16'(cyc), 16'd3);

        // R9: set bit 7
        run(4'd9, 1'b1, 1'b0, 16'h0001, 3'd7, 16'h0031, 16'h0300, 16'h0, cyc);
        @(negedge clk);
        chk(mem[10'h0CE] == 8'hB1, "R9", "bit set", {8'h0, mem[10'h0CE]}, 16'h00B1);

        // R7: post-increment word store
        run(4'd7, 1'b1, 1'b1, 16'hBEEF, 3'd0, 16'h0044, 16'h0200, 16'h0, cyc);
        @(negedge clk);
        chk(mem[10'h200] == 8'hBE && mem[10'h201] == 8'hEF, "R7", "inc store data",
            {mem[10'h200], mem[10'h201]}, 16'hBEEF);
        chk(hx_out == 16'h0201 && hx_upd, "R7", "inc value", hx_out, 16'h0201);
        chk(cyc == 2 && pc_out == 16'h0044, "R7", "inc cycles", 16'(cyc), 16'd2);

        // R10: bit-mode store refused at operand fetch makes no write
        w0 = wr_count;
        run(4'd9, 1'b1, 1'b0, 16'h0001, 3'd0, 16'hEE00, 16'h0300, 16'h0, cyc);
        @(negedge clk);
        chk(err && wr_count == w0, "R10", "rmw reject", 16'(wr_count - w0), 16'h0);
        chk(pc_out == 16'hEE00, "R10", "rmw reject pc", pc_out, 16'hEE00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule